// File: doc/BRIEF.md
# SPI Control Register Target

This block is a serial register target for board-control logic. A host drives a four-wire serial link in mode 0: the clock idles low and both sides sample on its rising edge. Every transaction is one fixed frame of 24 bits, sent most significant bit first. The top bit selects a read, the next seven bits name a register, and the low sixteen bits carry the data. On a read, the target returns the selected register on the data-out line during the sixteen data bit times.

The register file holds three mapped registers:

- a read-only revision word made of a major and a minor number;
- a reset-control register whose write emits a self-clearing hard-reset pulse to an attached transceiver;
- a read-only status word that reports the lock state of the transmit and receive local oscillators as separate bits.

The serial pins are resynchronised into the system clock domain, so the serial clock must run well below the system clock. Raising chip-select part way through a frame discards the frame.

Top module: `spi_reg_target`

## Requirements
- R1: A frame is 24 bits, most significant bit first, sampled on rising serial-clock edges while chip-select is low. Bit 23 is the read flag (1 = read, 0 = write), bits 22:16 are the register address and bits 15:0 are the data.
- R2: A read of address 0x00 returns the revision word, with the major number in bits 15:8 and the minor number in bits 7:0.
- R3: On a read, the data-out line presents register bit 15 before the ninth rising serial-clock edge of the frame. It then steps one bit lower after each following falling edge, so the host captures bits 15 down to 0 on rising edges 9 to 24.
- R4: A read of address 0x11 returns the transmit-oscillator lock in bit 0 and the receive-oscillator lock in bit 1. All other bits read zero.
- R5: A write to address 0x10 with data bit 0 set drives the transceiver reset output high for exactly PULSE_CYCLES system clocks, as one pulse. A qualifying write that arrives while a pulse is active neither extends nor restarts it.
- R6: A write to address 0x10 with data bit 0 clear produces no pulse. Reads of address 0x10 return zero.
- R7: If chip-select rises before the 24th rising edge, the frame is discarded: no write takes effect and the next frame decodes from its first bit.
- R8: Reads of unmapped addresses return zero. Writes to unmapped addresses and to the read-only addresses 0x00 and 0x11 change nothing.
- R9: Rising edges after the 24th within one chip-select period are ignored and cause no second write. A read frame has no write side effect, whatever its data bits.
- R10: The data-out line is low while chip-select is high and during the eight header bit times of every frame.
- R11: After reset, the transceiver reset output and the data-out line are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from the host, idles low |
| spi_cs_ni | input | 1 | Active-low chip-select |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| tx_lo_lock_i | input | 1 | Transmit local oscillator lock, asynchronous |
| rx_lo_lock_i | input | 1 | Receive local oscillator lock, asynchronous |
| xcvr_rst_o | output | 1 | Self-clearing hard-reset pulse to the transceiver |

## Verification
The bench builds the block with PULSE_CYCLES set to 6 and with revision numbers 0x3A and 0xC5. The short pulse lets a whole reset pulse and its exact width be observed between two frames. The asymmetric revision word makes any bit-order or byte-swap fault visible on the data-out line. The defaults are kept for the 7-bit address, 16-bit data, two synchroniser stages and synchronised lock inputs. With those settings the frame arithmetic is the 24-bit one described above, and truncated, overlong and read-only frames can all be driven within a few microseconds each.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

   // Register map (address values are part of the host contract)
   localparam int unsigned REG_REVISION = 32'h00;
   localparam int unsigned REG_XCVR_RST = 32'h10;
   localparam int unsigned REG_LO_LOCK  = 32'h11;

   // Bit positions inside the lock status word
   localparam int unsigned LOCK_TX_BIT  = 0;
   localparam int unsigned LOCK_RX_BIT  = 1;

   // Bit inside the reset-control data that triggers the pulse
   localparam int unsigned XRST_GO_BIT  = 0;

   function automatic int unsigned frame_bits(input int unsigned aw, input int unsigned dw);
      return 1 + aw + dw;
   endfunction

   function automatic int unsigned header_bits(input int unsigned aw);
      return 1 + aw;
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned          WIDTH     = 1,
   parameter int unsigned          STAGES    = 2,
   parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_pin_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_reg_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              cs_ni,
   input  logic              mosi_i,
   // write port towards the register file
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   // read port towards the register file
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              miso_o
);

   localparam int unsigned FRAME_W = frame_bits(ADDR_W, DATA_W);
   localparam int unsigned HDR_W   = header_bits(ADDR_W);
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(HDR_W);

   if (DATA_W < 2) begin : g_bad_data
      $error("spi_frame_engine: DATA_W must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("spi_frame_engine: ADDR_W must be at least 1");
   end

   logic               sclk_d_q;
   logic [CNT_W-1:0]   bit_cnt_q;
   logic [FRAME_W-1:0] shift_q;
   logic [DATA_W-1:0]  tx_q;
   logic               rd_mode_q;

   logic               sclk_rise;
   logic               sclk_fall;
   logic               take_bit;
   logic [FRAME_W-1:0] shift_nxt;
   logic               hdr_done;
   logic               frame_done;
   logic               rd_start;

   assign sclk_rise  = sclk_i & ~sclk_d_q;
   assign sclk_fall  = ~sclk_i & sclk_d_q;
   assign take_bit   = sclk_rise & ~cs_ni & (bit_cnt_q != CNT_FULL);
   assign shift_nxt  = {shift_q[FRAME_W-2:0], mosi_i};

   assign hdr_done   = take_bit & (bit_cnt_q == CNT_HDR);
   assign frame_done = take_bit & (bit_cnt_q == CNT_LAST);

   // header is complete in shift_nxt when hdr_done: flag above the address
   assign rd_start   = hdr_done & shift_nxt[HDR_W-1];
   assign rd_addr_o  = shift_nxt[ADDR_W-1:0];

   // full frame is present in shift_nxt when frame_done
   assign wr_en_o    = frame_done & ~shift_nxt[FRAME_W-1];
   assign wr_addr_o  = shift_nxt[DATA_W +: ADDR_W];
   assign wr_data_o  = shift_nxt[DATA_W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_d_q <= 1'b0;
      end else begin
         sclk_d_q <= sclk_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt_q <= '0;
         shift_q   <= '0;
         tx_q      <= '0;
         rd_mode_q <= 1'b0;
      end else if (cs_ni) begin
         bit_cnt_q <= '0;
         shift_q   <= '0;
         tx_q      <= '0;
         rd_mode_q <= 1'b0;
      end else if (take_bit) begin
         shift_q   <= shift_nxt;
         bit_cnt_q <= bit_cnt_q + 1'b1;
         if (rd_start) begin
            rd_mode_q <= 1'b1;
            tx_q      <= rd_data_i;
         end
      end else if (sclk_fall && rd_mode_q && (bit_cnt_q > CNT_DATA)) begin
         tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
   end

   assign miso_o = rd_mode_q & tx_q[DATA_W-1];

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import spi_reg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned REV_MAJOR    = 1,
   parameter int unsigned REV_MINOR    = 0,
   parameter int unsigned PULSE_CYCLES = 16,
   parameter bit          LOCK_SYNC    = 1'b1,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              tx_lock_i,
   input  logic              rx_lock_i,
   output logic              xcvr_rst_o
);

   localparam int unsigned REV_W = DATA_W / 2;
   localparam int unsigned PCW   = $clog2(PULSE_CYCLES + 1);
   localparam logic [PCW-1:0] PULSE_LOAD = PCW'(PULSE_CYCLES);
   localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(REG_REVISION);
   localparam logic [ADDR_W-1:0] A_XRST = ADDR_W'(REG_XCVR_RST);
   localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(REG_LO_LOCK);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("ctl_reg_bank: PULSE_CYCLES must be at least 1");
   end
   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_data
      $error("ctl_reg_bank: DATA_W must be even and at least 4");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ctl_reg_bank: ADDR_W too narrow for the register map");
   end
   if (REV_MAJOR >= (1 << REV_W) || REV_MINOR >= (1 << REV_W)) begin : g_bad_rev
      $error("ctl_reg_bank: revision number does not fit its field");
   end

   // ---------------- lock status inputs ----------------
   logic [1:0] lock_raw;
   logic [1:0] lock_s;

   assign lock_raw[LOCK_TX_BIT] = tx_lock_i;
   assign lock_raw[LOCK_RX_BIT] = rx_lock_i;

   if (LOCK_SYNC) begin : g_lock_sync
      spi_pin_sync #(
         .WIDTH     (2),
         .STAGES    (SYNC_STAGES),
         .RESET_VAL (2'b00)
      ) u_lock_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (lock_raw),
         .q_o    (lock_s)
      );
   end else begin : g_lock_direct
      assign lock_s = lock_raw;
   end

   // ---------------- reset pulse generator ----------------
   logic [PCW-1:0] pulse_cnt_q;
   logic           pulse_go;
   logic           unused_wr_hi;

   assign pulse_go     = wr_en_i & (wr_addr_i == A_XRST) & wr_data_i[XRST_GO_BIT];
   assign unused_wr_hi = ^wr_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pulse_cnt_q <= '0;
      end else if (pulse_cnt_q != '0) begin
         pulse_cnt_q <= pulse_cnt_q - 1'b1;
      end else if (pulse_go) begin
         pulse_cnt_q <= PULSE_LOAD;
      end
   end

   assign xcvr_rst_o = (pulse_cnt_q != '0);

   // ---------------- read multiplexer ----------------
   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == A_REV) begin
         rd_data_o[DATA_W-1:REV_W] = REV_W'(REV_MAJOR);
         rd_data_o[REV_W-1:0]      = REV_W'(REV_MINOR);
      end else if (rd_addr_i == A_LOCK) begin
         rd_data_o[LOCK_TX_BIT] = lock_s[LOCK_TX_BIT];
         rd_data_o[LOCK_RX_BIT] = lock_s[LOCK_RX_BIT];
      end
   end

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
   import spi_reg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned REV_MAJOR    = 1,
   parameter int unsigned REV_MINOR    = 0,
   parameter int unsigned PULSE_CYCLES = 16,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          LOCK_SYNC    = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic spi_sclk_i,
   input  logic spi_cs_ni,
   input  logic spi_mosi_i,
   output logic spi_miso_o,
   input  logic tx_lo_lock_i,
   input  logic rx_lo_lock_i,
   output logic xcvr_rst_o
);

   localparam int unsigned FRAME_W = frame_bits(ADDR_W, DATA_W);

   if (FRAME_W > 64) begin : g_bad_frame
      $error("spi_reg_target: frame wider than 64 bits");
   end

   logic              sclk_s;
   logic              cs_n_s;
   logic              mosi_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   // pin order {sclk, cs_n, mosi}; chip-select resets deasserted
   spi_pin_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (3'b010)
   ) u_pin_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({spi_sclk_i, spi_cs_ni, spi_mosi_i}),
      .q_o    ({sclk_s, cs_n_s, mosi_s})
   );

   spi_frame_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sclk_i    (sclk_s),
      .cs_ni     (cs_n_s),
      .mosi_i    (mosi_s),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data),
      .miso_o    (spi_miso_o)
   );

   ctl_reg_bank #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .REV_MAJOR    (REV_MAJOR),
      .REV_MINOR    (REV_MINOR),
      .PULSE_CYCLES (PULSE_CYCLES),
      .LOCK_SYNC    (LOCK_SYNC),
      .SYNC_STAGES  (SYNC_STAGES)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .tx_lock_i  (tx_lo_lock_i),
      .rx_lock_i  (rx_lo_lock_i),
      .xcvr_rst_o (xcvr_rst_o)
   );

endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk
   import spi_reg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned PULSE_CYCLES = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              spi_cs_ni,
   input logic              spi_miso_o,
   input logic              xcvr_rst_o,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data
);

   localparam int unsigned CS_SETTLE = SYNC_STAGES + 2;

   int unsigned run_len;
   int unsigned cs_hi_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_len   <= 0;
         cs_hi_cnt <= 0;
      end else begin
         run_len <= xcvr_rst_o ? run_len + 1 : 0;
         if (!spi_cs_ni) begin
            cs_hi_cnt <= 0;
         end else if (cs_hi_cnt < CS_SETTLE) begin
            cs_hi_cnt <= cs_hi_cnt + 1;
         end
      end
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(xcvr_rst_o) |-> (run_len == PULSE_CYCLES)); // R5

   AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_len <= PULSE_CYCLES); // R5

   AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(xcvr_rst_o) |->
         $past(wr_en && (wr_addr == ADDR_W'(REG_XCVR_RST)) && wr_data[XRST_GO_BIT])); // R6

   AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_hi_cnt >= CS_SETTLE) |-> !spi_miso_o); // R10

   AST_WRITE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en |-> (cs_hi_cnt < CS_SETTLE)); // R7

endmodule

bind spi_reg_target spi_reg_target_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .PULSE_CYCLES (PULSE_CYCLES),
   .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .spi_cs_ni  (spi_cs_ni),
   .spi_miso_o (spi_miso_o),
   .xcvr_rst_o (xcvr_rst_o),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data)
);

// File: tb/spi_reg_target_tb.sv
`timescale 1ns/1ps
module spi_reg_target_tb;

   localparam int PULSE   = 6;
   localparam int HALF    = 64;   // serial half period, 8 system clocks
   localparam logic [15:0] REV_WORD = 16'h3AC5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;
   logic tx_lock = 1'b0;
   logic rx_lock = 1'b0;
   logic xcvr_rst;

   int checks = 0;
   int errors = 0;
   int pulse_hi = 0;
   int pulse_rise = 0;
   logic prev_rst = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   spi_reg_target #(
      .REV_MAJOR    (8'h3A),
      .REV_MINOR    (8'hC5),
      .PULSE_CYCLES (PULSE)
   ) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .spi_sclk_i   (spi_sclk),
      .spi_cs_ni    (spi_cs_n),
      .spi_mosi_i   (spi_mosi),
      .spi_miso_o   (spi_miso),
      .tx_lo_lock_i (tx_lock),
      .rx_lo_lock_i (rx_lock),
      .xcvr_rst_o   (xcvr_rst)
   );

   always @(negedge clk) begin
      if (xcvr_rst === 1'b1) pulse_hi++;
      if (xcvr_rst === 1'b1 && prev_rst === 1'b0) pulse_rise++;
      prev_rst = xcvr_rst;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one chip-select period with nclk serial clocks
   task automatic xfer(input logic rd, input logic [6:0] addr, input logic [15:0] data,
                       input int nclk, output logic [15:0] rdata, output logic hdr_quiet);
      logic [23:0] f;
      f = {rd, addr, data};
      rdata = '0;
      hdr_quiet = 1'b1;
      spi_cs_n = 1'b0;
      #(HALF);
      for (int i = 0; i < nclk; i++) begin
         spi_mosi = (i < 24) ? f[23-i] : 1'b0;
         #(HALF);
         if (i < 8) begin
            if (spi_miso !== 1'b0) hdr_quiet = 1'b0;
         end else if (i < 24) begin
            rdata[23-i] = spi_miso;
         end
         spi_sclk = 1'b1;
         #(HALF);
         spi_sclk = 1'b0;
      end
      #(HALF);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      #(4*HALF);
   endtask

   task automatic clear_pulse();
      pulse_hi = 0;
      pulse_rise = 0;
   endtask

   task automatic t_reset_state();
      chk("R11 miso after reset", {31'b0, spi_miso}, 32'h0);
      chk("R11 xcvr_rst after reset", {31'b0, xcvr_rst}, 32'h0);
   endtask

   task automatic t_revision();
      logic [15:0] rd; logic q;
      xfer(1'b1, 7'h00, 16'h0000, 24, rd, q);
      chk("R2 R3 R1 revision word", {16'b0, rd}, {16'b0, REV_WORD});
      chk("R10 header quiet on read", {31'b0, q}, 32'h1);
      chk("R10 miso low after frame", {31'b0, spi_miso}, 32'h0);
   endtask

   task automatic t_lock();
      logic [15:0] rd; logic q;
      tx_lock = 1'b1; rx_lock = 1'b0; #(HALF);
      xfer(1'b1, 7'h11, 16'h0000, 24, rd, q);
      chk("R4 tx lock only", {16'b0, rd}, 32'h1);
      tx_lock = 1'b0; rx_lock = 1'b1; #(HALF);
      xfer(1'b1, 7'h11, 16'hFFFF, 24, rd, q);
      chk("R4 rx lock only", {16'b0, rd}, 32'h2);
      tx_lock = 1'b1; rx_lock = 1'b1; #(HALF);
      xfer(1'b1, 7'h11, 16'h0000, 24, rd, q);
      chk("R4 both locks", {16'b0, rd}, 32'h3);
   endtask

   task automatic t_pulse();
      logic [15:0] rd; logic q;
      clear_pulse();
      xfer(1'b0, 7'h10, 16'h0001, 24, rd, q);
      chk("R5 pulse width", pulse_hi, PULSE);
      chk("R5 single pulse", pulse_rise, 1);
      chk("R11 xcvr_rst low after pulse", {31'b0, xcvr_rst}, 32'h0);
   endtask

   task automatic t_no_go();
      logic [15:0] rd; logic q;
      clear_pulse();
      xfer(1'b0, 7'h10, 16'hFFFE, 24, rd, q);
      chk("R6 bit0 clear gives no pulse", pulse_rise, 0);
      xfer(1'b1, 7'h10, 16'hFFFF, 24, rd, q);
      chk("R6 reset reg reads zero", {16'b0, rd}, 32'h0);
      chk("R9 read frame no side effect", pulse_rise, 0);
   endtask

   task automatic t_abort();
      logic [15:0] rd; logic q;
      clear_pulse();
      xfer(1'b0, 7'h10, 16'h0001, 20, rd, q);
      chk("R7 abort at 20 bits", pulse_rise, 0);
      xfer(1'b0, 7'h10, 16'h0001, 23, rd, q);
      chk("R7 abort at 23 bits", pulse_rise, 0);
      xfer(1'b1, 7'h00, 16'h0000, 24, rd, q);
      chk("R7 next frame decodes", {16'b0, rd}, {16'b0, REV_WORD});
   endtask

   task automatic t_unmapped();
      logic [15:0] rd; logic q;
      clear_pulse();
      xfer(1'b1, 7'h05, 16'h0000, 24, rd, q);
      chk("R8 unmapped 0x05 reads zero", {16'b0, rd}, 32'h0);
      xfer(1'b1, 7'h7F, 16'h0000, 24, rd, q);
      chk("R8 unmapped 0x7F reads zero", {16'b0, rd}, 32'h0);
      xfer(1'b0, 7'h00, 16'h1234, 24, rd, q);
      xfer(1'b0, 7'h05, 16'h0001, 24, rd, q);
      xfer(1'b0, 7'h11, 16'h0001, 24, rd, q);
      chk("R8 ignored writes give no pulse", pulse_rise, 0);
      xfer(1'b1, 7'h00, 16'h0000, 24, rd, q);
      chk("R8 revision unchanged", {16'b0, rd}, {16'b0, REV_WORD});
   endtask

   task automatic t_overlong();
      logic [15:0] rd; logic q;
      clear_pulse();
      xfer(1'b0, 7'h10, 16'h0001, 30, rd, q);
      chk("R9 one pulse for overlong frame", pulse_rise, 1);
      chk("R9 pulse width for overlong frame", pulse_hi, PULSE);
   endtask

   initial begin : watchdog
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      #2;
      repeat (5) @(negedge clk);
      #2;
      t_reset_state();
      rst_n = 1'b1;
      #(4*HALF);
      t_reset_state();
      t_revision();
      t_lock();
      t_pulse();
      t_no_go();
      t_abort();
      t_unmapped();
      t_overlong();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule